// File: doc/BRIEF.md
# I2C Bit-Timing Divider

This block derives the bit timing of an I2C master from the system clock. Two counters run in series. The first is a linear prescaler that divides by (M+1). The second is a power-of-two stage that divides the prescaler output by 2^(N+1). Each time the second stage wraps, the block emits a one-cycle sample tick. The sample tick runs at ten times the SCL rate. A derived square wave at the SCL rate is also produced, toggling once every five sample ticks.

Software loads both divisors with a single synchronous write of a 7-bit configuration word. Loading a word restarts every counter, so the first tick after a write is always a full period away. Deasserting the enable input parks the counters at zero and silences both outputs.

Top module: `i2c_baud_div`

## Requirements
- R1: The configuration word takes the linear divisor M from bits 6:3 and the power-of-two exponent N from bits 2:0. M spans 0..15 and N spans 0..7, and the word is captured on a clock edge where cfgWrEn is high.
- R2: While enabled, sampleTick is a single-cycle pulse that repeats every P = (M+1) * 2^(N+1) clock cycles.
- R3: A configuration write clears both counter stages. If the write is captured at edge E, the first tick is high in the cycle that begins P-1 edges after E.
- R4: sclClk starts low after a restart and toggles on the edge that follows every fifth sampleTick. This gives a 50% duty square wave of period 10 * P cycles.
- R5: While enable is low, no ticks are produced, the counters and the phase stay at zero, and sclClk is driven low from the next edge onward. Re-enabling then behaves like a restart.
- R6: After reset the configuration word is zero, giving P = 2, and both outputs are low.
- R7: No tick is produced in the cycle in which a configuration write is presented, nor in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Divider run enable; low holds all counters at zero |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 7 | Configuration word: M in 6:3, N in 2:0 |
| sampleTick | output | 1 | One-cycle pulse at ten times the SCL rate |
| sclClk | output | 1 | SCL-rate square wave, 50% duty |

## Verification
The hardest behaviour to reach from the ports is the largest setting, M=15 and N=7, where the power-of-two stage uses its full width and one tick period is 4096 cycles. The stimulus loads that word directly and times two consecutive ticks.

A second hard point is a restart that lands mid-count. The stimulus rewrites the same word a few cycles into a period, so that only the clearing of partially advanced counters can explain the delay to the next tick. It likewise drops enable while sclClk is high, which shows that the phase state is cleared and not merely paused.

// File: rtl/i2c_baud_div_pkg.sv
`timescale 1ns/1ps
package i2c_baud_div_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // force both stages to zero
    logic step;    // advance the prescaler by one clock
  } divStrobe_t;

  // Terminal-count flags returned by the datapath
  typedef struct packed {
    logic preDone; // prescaler at its last count
    logic powDone; // power-of-two stage at its last count
  } divFlags_t;

endpackage

// File: rtl/i2c_baud_datapath.sv
`timescale 1ns/1ps
module i2c_baud_datapath
  import i2c_baud_div_pkg::*;
#(
  parameter int M_WIDTH = 4,
  parameter int N_WIDTH = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strobe,
  input  logic [M_WIDTH-1:0] mVal,
  input  logic [N_WIDTH-1:0] nVal,
  output divFlags_t          flags
);

  // Largest second-stage ratio is 2^(2^N_WIDTH), so its counter needs 2^N_WIDTH bits
  localparam int POW_W = 1 << N_WIDTH;
  localparam logic [POW_W-1:0] POW_ONES = '1;
  localparam logic [N_WIDTH-1:0] TOP_EXP = N_WIDTH'(POW_W - 1);

  logic [M_WIDTH-1:0] preCnt;
  logic [POW_W-1:0]   powCnt;
  logic [POW_W-1:0]   powLast;

  // Last count of the second stage is 2^(N+1)-1: a run of N+1 ones
  assign powLast = POW_ONES >> (TOP_EXP - nVal);

  assign flags.preDone = (preCnt == mVal);
  assign flags.powDone = (powCnt == powLast);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      preCnt <= '0;
      powCnt <= '0;
    end else if (strobe.step) begin
      if (flags.preDone) begin
        preCnt <= '0;
        if (flags.powDone) powCnt <= '0;
        else               powCnt <= powCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_baud_ctrl.sv
`timescale 1ns/1ps
module i2c_baud_ctrl
  import i2c_baud_div_pkg::*;
#(
  parameter int M_WIDTH    = 4,
  parameter int N_WIDTH    = 3,
  parameter int HALF_TICKS = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       cfgWrEn,
  input  logic [M_WIDTH+N_WIDTH-1:0] cfgWrData,
  input  divFlags_t                  flags,
  output divStrobe_t                 strobe,
  output logic [M_WIDTH-1:0]         mVal,
  output logic [N_WIDTH-1:0]         nVal,
  output logic                       sampleTick,
  output logic                       sclClk
);

  localparam int FIELD_W = M_WIDTH + N_WIDTH;
  localparam int PH_W    = $clog2(HALF_TICKS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_TICKS - 1);

  logic [FIELD_W-1:0] cfgReg;
  logic [PH_W-1:0]    phase;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= '0;
    else if (cfgWrEn) cfgReg <= cfgWrData;
  end

  assign mVal = cfgReg[FIELD_W-1:N_WIDTH];
  assign nVal = cfgReg[N_WIDTH-1:0];

  // A write or a disable restarts everything; otherwise count each clock
  assign strobe.clear = cfgWrEn || !enable;
  assign strobe.step  = !strobe.clear;

  assign sampleTick = strobe.step && flags.preDone && flags.powDone;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      phase  <= '0;
      sclClk <= 1'b0;
    end else if (sampleTick) begin
      if (phase == PH_LAST) begin
        phase  <= '0;
        sclClk <= !sclClk;
      end else begin
        phase  <= phase + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_baud_div.sv
`timescale 1ns/1ps
module i2c_baud_div
  import i2c_baud_div_pkg::*;
#(
  parameter int M_WIDTH    = 4,
  parameter int N_WIDTH    = 3,
  parameter int HALF_TICKS = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       cfgWrEn,
  input  logic [M_WIDTH+N_WIDTH-1:0] cfgWrData,
  output logic                       sampleTick,
  output logic                       sclClk
);

  divStrobe_t         strobe;
  divFlags_t          flags;
  logic [M_WIDTH-1:0] mVal;
  logic [N_WIDTH-1:0] nVal;

  i2c_baud_ctrl #(
    .M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH), .HALF_TICKS(HALF_TICKS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .flags(flags), .strobe(strobe),
    .mVal(mVal), .nVal(nVal),
    .sampleTick(sampleTick), .sclClk(sclClk)
  );

  i2c_baud_datapath #(
    .M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .mVal(mVal), .nVal(nVal), .flags(flags)
  );

endmodule

// File: rtl/i2c_baud_div_chk.sv
`timescale 1ns/1ps
module i2c_baud_div_chk #(
  parameter int M_WIDTH    = 4,
  parameter int N_WIDTH    = 3,
  parameter int HALF_TICKS = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       enable,
  input logic                       cfgWrEn,
  input logic [M_WIDTH+N_WIDTH-1:0] cfgWrData,
  input logic                       sampleTick,
  input logic                       sclClk
);

  // Shadow of the configuration, rebuilt from the write port
  logic [M_WIDTH-1:0] shM;
  logic [N_WIDTH-1:0] shN;
  logic [31:0]        period;
  logic [31:0]        gap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shM <= '0;
      shN <= '0;
    end else if (cfgWrEn) begin
      shM <= cfgWrData[M_WIDTH+N_WIDTH-1:N_WIDTH];
      shN <= cfgWrData[N_WIDTH-1:0];
    end
  end

  assign period = (32'(shM) + 32'd1) << (32'(shN) + 32'd1);

  // Cycles since the last restart or tick
  always_ff @(posedge clk) begin
    if (!rstN || cfgWrEn || !enable || sampleTick) gap <= '0;
    else                                           gap <= gap + 32'd1;
  end

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> (gap == period - 32'd1));

  // R2
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick);

  // R5
  no_tick_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !sampleTick);

  // R5
  scl_low_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclClk);

  // R7
  no_tick_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> !sampleTick);

  // R4
  scl_toggle_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclClk) |-> ($past(sampleTick) || $past(cfgWrEn) || !$past(enable)));

endmodule

bind i2c_baud_div i2c_baud_div_chk #(
  .M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH), .HALF_TICKS(HALF_TICKS)
) chk (.*);

// File: tb/i2c_baud_div_test.sv
`timescale 1ns/1ps
module i2c_baud_div_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       cfgWrEn = 1'b0;
  logic [6:0] cfgWrData = '0;
  logic       sampleTick;
  logic       sclClk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = !clk;  // 50 MHz

  i2c_baud_div uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .sampleTick(sampleTick), .sclClk(sclClk)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stepClk();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [6:0] mkCfg(int m, int n);
    return {4'(m), 3'(n)};
  endfunction

  // Leaves time at step 0: first cycle after the write edge
  task automatic writeCfg(logic [6:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    #1;
    check("R7", "tick during write cycle", int'(sampleTick), 0);
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
    check("R7", "tick in cycle after write", int'(sampleTick), 0);
  endtask

  // From step 0, first tick at P-1, next exactly P later
  task automatic measureTicks(string req, int p);
    int n = 0;
    int m;
    while (!sampleTick && n < 5000) begin
      stepClk();
      n++;
    end
    check(req, "cycles to first tick", n, p - 1);
    stepClk();
    check(req, "tick width one cycle", int'(sampleTick), 0);
    m = 1;
    while (!sampleTick && m < 5000) begin
      stepClk();
      m++;
    end
    check(req, "tick spacing", m, p);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R6", "tick in reset", int'(sampleTick), 0);
    check("R6", "scl in reset", int'(sclClk), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    measureTicks("R6", 2);
  endtask

  task automatic testPeriods();
    writeCfg(mkCfg(0, 0)); measureTicks("R2", 2);
    writeCfg(mkCfg(3, 1)); measureTicks("R2", 16);
    writeCfg(mkCfg(15, 0)); measureTicks("R1", 32);
    writeCfg(mkCfg(0, 2)); measureTicks("R1", 8);
    writeCfg(mkCfg(2, 3)); measureTicks("R3", 48);
    writeCfg(mkCfg(15, 7)); measureTicks("R2", 4096);
  endtask

  task automatic testScl();
    int p = 4;
    int tickErr = 0;
    int sclErr = 0;
    writeCfg(mkCfg(1, 0));
    for (int s = 0; s < 30 * p; s++) begin
      if (int'(sampleTick) != int'(((s + 1) % p) == 0)) tickErr++;
      if (int'(sclClk) != ((s / (5 * p)) % 2)) sclErr++;
      stepClk();
    end
    check("R4", "tick pattern mismatches", tickErr, 0);
    check("R4", "scl waveform mismatches", sclErr, 0);
  endtask

  task automatic testEnable();
    int seen = 0;
    writeCfg(mkCfg(1, 1));
    repeat (3) stepClk();
    @(negedge clk);
    enable = 1'b0;
    #1;
    for (int s = 0; s < 20; s++) begin
      if (sampleTick || sclClk) seen++;
      stepClk();
    end
    check("R5", "activity while disabled", seen, 0);
    @(negedge clk);
    enable = 1'b1;
    #1;
    measureTicks("R5", 8);
    // scl high then disable clears it
    writeCfg(mkCfg(0, 0));
    repeat (10) stepClk();
    check("R4", "scl high after five ticks", int'(sclClk), 1);
    @(negedge clk);
    enable = 1'b0;
    #1;
    stepClk();
    check("R5", "scl low after disable", int'(sclClk), 0);
    @(negedge clk);
    enable = 1'b1;
    #1;
  endtask

  task automatic testRestart();
    writeCfg(mkCfg(1, 1));
    repeat (5) stepClk();
    writeCfg(mkCfg(1, 1));
    measureTicks("R3", 8);
  endtask

  initial begin
    testReset();
    testPeriods();
    testScl();
    testEnable();
    testRestart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule